// File: doc/BRIEF.md
# Keyed Watchdog Timer with Two-Stage Expiry

This block is a countdown watchdog for a system that supplies a slow time base as a one-cycle tick strobe (nominally a 32 kHz rate). Software programs an interval, enables the counter, and then keeps rewriting a restart code before the interval runs out. If it stops doing so, the block ends the interval. In single-stage operation it then issues a fixed-width system reset pulse. In two-stage operation it first raises a level interrupt and counts the same interval a second time, and the reset follows only if software still does not restart it.

The register bus is a flat write-strobe bus with a combinational read port. Each of the four registers accepts a write only when the write data carries that register's own key pattern. This keeps a stray store from disabling the watchdog, changing its interval, restarting it or resetting the system. A software-reset register fires the reset pulse directly. An external reset pin mirrors the reset pulse with a programmable active level and can be turned off.

Top module: `keyed_wdog`

## Requirements
- R1: After rst_ni is released, irq_o and sys_rst_o are 0, ext_rst_o is 1, the control register (offset 0x00) reads 0, and the length register (offset 0x04) reads the reset interval shifted left by 5.
- R2: A write to offset 0x00 updates the control bits only when wdata_i[31:24] is 0x22; otherwise nothing changes. Control bit layout: bit 0 enable, bit 1 pin polarity (1 = active high), bit 2 pin enable, bit 3 interrupt enable, bit 4 auto-restart, bit 6 two-stage enable. Reads return these bits, with the key field read as zero.
- R3: A write to offset 0x04 updates the interval only when wdata_i[4:0] is 0x08. The interval is taken from bits 5 upward. Reads return the interval at bit 5 and zero in bits 4:0.
- R4: Once the counter has been started (a keyed enable write while disabled) or restarted, it expires after interval × 512 tick strobes. With a tick on every cycle and two-stage mode off, sys_rst_o rises exactly interval × 512 cycles after the write edge.
- R5: Every system reset pulse lasts exactly 16 clock cycles. A trigger that arrives while a pulse is active is ignored.
- R6: Writing 0x00001971 to offset 0x08 reloads the full interval and clears irq_o. Any other value at 0x08 has no effect.
- R7: In two-stage mode, the first expiry reloads the interval and sets irq_o if interrupt enable is set. irq_o then holds its level, and the second expiry raises the reset: the interrupt comes at N cycles and the reset at 2N cycles after the start.
- R8: A keyed write that clears the enable bit stops the counter and clears irq_o. No interrupt or reset follows.
- R9: ext_rst_o is at its active level (the polarity bit) while sys_rst_o is high and pin enable is set. In every other case it is at the inactive level, the inverse of the polarity bit.
- R10: Writing 0x00001209 to offset 0x14 raises sys_rst_o at the write edge, whether the counter is enabled or not. Other values are ignored.
- R11: At a final expiry with auto-restart set, the counter reloads and starts stage one again. Without auto-restart it stays halted until a restart write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one count per high cycle |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data including key |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Level pre-expiry interrupt |
| sys_rst_o | output | 1 | Active-high system reset pulse |
| ext_rst_o | output | 1 | External reset pin, programmable polarity |

## Verification
With tick_i held high, all timing results land at a fixed cycle measured from the edge at which the write is sampled. The software reset appears on that same edge. Interrupt and reset appear N and 2N edges after a start or restart edge, and the reset pulse stays high for 16 negative-edge samples. The driver records the edge number of every write and places the event it predicts, with its due cycle, into a queue. A monitor sampling on the falling edge compares each rising edge of irq_o and sys_rst_o against the head of that queue, so an early, late or unexpected event is reported as a mismatch.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [4:0]  OFS_CTRL    = 5'h00;
  localparam logic [4:0]  OFS_LEN     = 5'h04;
  localparam logic [4:0]  OFS_KICK    = 5'h08;
  localparam logic [4:0]  OFS_SWRST   = 5'h14;
  localparam logic [7:0]  CTRL_KEY    = 8'h22;
  localparam logic [4:0]  LEN_KEY     = 5'h08;
  localparam int          LEN_LSB     = 5;
  localparam logic [31:0] KICK_CODE   = 32'h0000_1971;
  localparam logic [31:0] SWRST_CODE  = 32'h0000_1209;

  typedef struct packed {
    logic dual;
    logic auto_start;
    logic irq_en;
    logic ext_en;
    logic ext_pol;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2
  } stage_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LEN_W = 11,
  parameter logic [LEN_W-1:0] LEN_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  output ctrl_t             ctrl_o,
  output logic [LEN_W-1:0]  interval_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              kick_o,
  output logic              swrst_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(OFS_LEN);
  localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_SWRST = ADDR_W'(OFS_SWRST);

  ctrl_t            ctrl_q;
  logic [LEN_W-1:0] len_q;
  logic             ctrl_wr, len_wr;

  assign ctrl_wr = we_i && addr_i == A_CTRL && wdata_i[31:24] == CTRL_KEY;
  assign len_wr  = we_i && addr_i == A_LEN && wdata_i[4:0] == LEN_KEY;
  assign kick_o  = we_i && addr_i == A_KICK && wdata_i == KICK_CODE;
  assign swrst_o = we_i && addr_i == A_SWRST && wdata_i == SWRST_CODE;
  assign start_o = ctrl_wr && wdata_i[0] && !ctrl_q.en;
  assign stop_o  = ctrl_wr && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      len_q  <= LEN_RST;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.en         <= wdata_i[0];
        ctrl_q.ext_pol    <= wdata_i[1];
        ctrl_q.ext_en     <= wdata_i[2];
        ctrl_q.irq_en     <= wdata_i[3];
        ctrl_q.auto_start <= wdata_i[4];
        ctrl_q.dual       <= wdata_i[6];
      end
      if (len_wr) len_q <= wdata_i[LEN_LSB +: LEN_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[0] = ctrl_q.en;
      rdata_o[1] = ctrl_q.ext_pol;
      rdata_o[2] = ctrl_q.ext_en;
      rdata_o[3] = ctrl_q.irq_en;
      rdata_o[4] = ctrl_q.auto_start;
      rdata_o[6] = ctrl_q.dual;
    end else if (addr_i == A_LEN) begin
      rdata_o[LEN_LSB +: LEN_W] = len_q;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign interval_o = len_q;

  AST_CTRL_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && wdata_i[31:24] != CTRL_KEY) |=> $stable(ctrl_o)); // R2
  AST_LEN_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_LEN && wdata_i[4:0] != LEN_KEY) |=> $stable(interval_o)); // R3
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int UNIT_TICKS = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  ctrl_t            ctrl_i,
  input  logic [LEN_W-1:0] interval_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             kick_i,
  output logic             expire_o,
  output logic             irq_o
);
  localparam int CNT_W = LEN_W + $clog2(UNIT_TICKS) + 1;

  stage_e           stage_q;
  logic [CNT_W-1:0] cnt_q, load_val;
  logic             irq_q, running, last, reload;

  assign load_val = CNT_W'(interval_i) * CNT_W'(UNIT_TICKS);
  assign running  = stage_q != ST_IDLE;
  assign reload   = start_i || (kick_i && ctrl_i.en);
  // interval 0 expires on the first tick
  assign last     = running && ctrl_i.en && tick_i && cnt_q <= CNT_W'(1);
  assign expire_o = last && !stop_i && !reload && (stage_q == ST_TWO || !ctrl_i.dual);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
    end else if (stop_i) begin
      stage_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else if (reload) begin
      stage_q <= ST_ONE;
      cnt_q   <= load_val;
      irq_q   <= 1'b0;
    end else if (!ctrl_i.en) begin
      stage_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else if (last) begin
      if (stage_q == ST_ONE && ctrl_i.dual) begin
        stage_q <= ST_TWO;
        cnt_q   <= load_val;
        irq_q   <= ctrl_i.irq_en;
      end else begin
        irq_q <= 1'b0;
        if (ctrl_i.auto_start) begin
          stage_q <= ST_ONE;
          cnt_q   <= load_val;
        end else begin
          stage_q <= ST_IDLE;
        end
      end
    end else if (running && tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign irq_o = irq_q;

  AST_KICK_CLEARS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && ctrl_i.en) |=> !irq_o); // R6
  AST_IRQ_ONLY_DUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (ctrl_i.dual && ctrl_i.irq_en)); // R7
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!irq_o && !expire_o)); // R8
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int RST_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic ext_en_i,
  input  logic ext_pol_i,
  output logic sys_rst_o,
  output logic ext_rst_o
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        left_q <= '0;
    else if (left_q == '0 && trig_i)    left_q <= PW'(RST_LEN);
    else if (left_q != '0)              left_q <= left_q - PW'(1);
  end

  assign sys_rst_o = left_q != '0;
  assign ext_rst_o = (sys_rst_o && ext_en_i) ? ext_pol_i : !ext_pol_i;

  // independent width measure for the pulse check
  logic [PW:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_len_q <= '0;
    else if (sys_rst_o) hi_len_q <= hi_len_q + 1'b1;
    else                hi_len_q <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> hi_len_q == (PW+1)'(RST_LEN)); // R5
  AST_TRIG_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !sys_rst_o) |=> sys_rst_o); // R10
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LEN_W = 11,
  parameter int UNIT_TICKS = 512,
  parameter int RST_LEN = 16,
  parameter logic [LEN_W-1:0] LEN_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o,
  output logic              ext_rst_o
);
  ctrl_t            ctrl;
  logic [LEN_W-1:0] interval;
  logic             start, stop, kick, swrst, expire;

  wdog_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .ctrl_o(ctrl), .interval_o(interval), .start_o(start), .stop_o(stop),
    .kick_o(kick), .swrst_o(swrst)
  );

  wdog_count #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT_TICKS)) u_count (
    .clk_i, .rst_ni, .tick_i, .ctrl_i(ctrl), .interval_i(interval),
    .start_i(start), .stop_i(stop), .kick_i(kick),
    .expire_o(expire), .irq_o
  );

  wdog_rstgen #(.RST_LEN(RST_LEN)) u_rstgen (
    .clk_i, .rst_ni, .trig_i(expire | swrst),
    .ext_en_i(ctrl.ext_en), .ext_pol_i(ctrl.ext_pol),
    .sys_rst_o, .ext_rst_o
  );

  AST_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_o |-> ext_rst_o == !ctrl.ext_pol); // R9
endmodule

// File: tb/tb_keyed_wdog.sv
`timescale 1ns/1ps
module tb_keyed_wdog;
  localparam int N = 512;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b1;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq, srst, ext;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct { int kind; int at; } ev_t;  // kind 0 irq, 1 reset
  ev_t expq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_wdog dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .irq_o(irq),
    .sys_rst_o(srst), .ext_rst_o(ext)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, output int edge_at);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 edge_at = cyc;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic expect_ev(input int kind, input int at);
    ev_t e;
    e.kind = kind; e.at = at;
    expq.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: compare event rises to the queue head
  logic prev_irq = 1'b0, prev_rst = 1'b0;
  int   hi_cnt = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int k = 0; k < 2; k++) begin
        logic rose;
        rose = (k == 0) ? (irq && !prev_irq) : (srst && !prev_rst);
        if (rose) begin
          checks++;
          if (expq.size() == 0) begin
            errors++;
            $display("FAIL R4/R7 unexpected %s at %0d", k ? "reset" : "irq", cyc);
          end else begin
            ev_t e;
            e = expq.pop_front();
            if (e.kind != k || e.at != cyc) begin
              errors++;
              $display("FAIL R4/R7 event kind %0d at %0d, expected kind %0d at %0d",
                       k, cyc, e.kind, e.at);
            end
          end
        end
      end
      if (srst) hi_cnt++;
      else if (prev_rst) begin
        check("R5 pulse width", hi_cnt, 16);
        hi_cnt = 0;
      end
      prev_irq = irq;
      prev_rst = srst;
    end
  end

  initial begin
    int w, r;
    logic [31:0] d;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 sys_rst", srst, 0);
    check("R1 ext pin", ext, 1);
    rd(5'h00, d); check("R1 ctrl", d, 0);
    rd(5'h04, d); check("R1 length", d, 32'h7ff << 5);

    // R2/R3 keys
    wr(5'h00, 32'h2300_0001, w);
    rd(5'h00, d); check("R2 unkeyed ctrl ignored", d, 0);
    wr(5'h04, 32'h0000_0020, w);
    rd(5'h04, d); check("R3 unkeyed length ignored", d, 32'h7ff << 5);
    wr(5'h04, 32'h0000_0028, w);
    rd(5'h04, d); check("R3 length key reads zero", d, 32'h20);
    idle(600);
    check("R2 no event while disabled", srst, 0);

    // R4/R6 single mode with restarts
    wr(5'h00, 32'h2200_0001, w);
    rd(5'h00, d); check("R2 ctrl readback", d, 32'h1);
    idle(100);
    wr(5'h08, 32'h0000_1970, r);  // wrong code
    idle(100);
    wr(5'h08, 32'h0000_1971, r);
    expect_ev(1, r + N);          // R6 reload, R4 timing
    idle(N + 40);
    check("R11 halted without auto", srst, 0);
    idle(700);                    // monitor flags any further reset
    check("R4 queue drained", expq.size(), 0);
    wr(5'h00, 32'h2200_0000, w);

    // R7 two-stage
    wr(5'h00, 32'h2200_0049, w);
    expect_ev(0, w + N);
    expect_ev(1, w + 2*N);
    idle(800);
    check("R7 irq level held", irq, 1);
    idle(N + 40);
    check("R7 queue drained", expq.size(), 0);
    wr(5'h00, 32'h2200_0000, w);
    check("R8 irq cleared by disable", irq, 0);

    // R6/R8 restart after irq, then disable
    wr(5'h00, 32'h2200_0049, w);
    expect_ev(0, w + N);
    idle(600);
    wr(5'h08, 32'h0000_1971, r);
    check("R6 restart clears irq", irq, 0);
    expect_ev(0, r + N);
    idle(700);
    wr(5'h00, 32'h2200_0000, w);
    idle(N + 600);
    check("R8 no reset after disable", srst, 0);
    check("R8 queue drained", expq.size(), 0);

    // R9/R10 software reset and pin polarity
    wr(5'h00, 32'h2200_0006, w);
    wr(5'h14, 32'h0000_1208, w);
    idle(3);
    check("R10 wrong code ignored", srst, 0);
    wr(5'h14, 32'h0000_1209, w);
    expect_ev(1, w);
    check("R9 pin active high", ext, 1);
    idle(20);
    check("R9 pin idle low", ext, 0);
    wr(5'h00, 32'h2200_0004, w);
    @(negedge clk);
    check("R9 pin idle high", ext, 1);
    wr(5'h14, 32'h0000_1209, w);
    expect_ev(1, w);
    check("R9 pin active low", ext, 0);
    idle(20);
    wr(5'h00, 32'h2200_0000, w);
    wr(5'h14, 32'h0000_1209, w);
    expect_ev(1, w);
    check("R9 pin disabled stays high", ext, 1);
    idle(20);

    // R11 auto-restart
    wr(5'h00, 32'h2200_0011, w);
    expect_ev(1, w + N);
    expect_ev(1, w + 2*N);
    idle(2*N + 10);
    wr(5'h00, 32'h2200_0000, w);
    idle(N + 40);
    check("R11 queue drained", expq.size(), 0);

    done = 1;
  end

  initial begin
    int limit = 50000;
    while (!done && limit > 0) begin
      @(posedge clk);
      limit--;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout at cycle %0d", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule